// File: doc/BRIEF.md
# Four-Channel Buffered PWM Controller

This block generates four independent pulse-width modulated outputs from one clock. Software programs each channel through a small memory-mapped register bus: a mode word that picks a clock prescaler, the output polarity and where buffered updates go, a period value, and a threshold value that splits each period into an inactive lead-in and an active tail. A per-channel counter runs from zero to period minus one on the prescaled clock. The output is active while the counter is at or above the threshold.

Running channels are retuned through a single buffered update register per channel. A write to it is held until the current period ends, and then loaded into the threshold or the period, as chosen by a mode bit. The waveform therefore never shows a partial period. Each period end also raises a per-channel event flag, visible in a clear-on-read status word and OR-ed onto an interrupt line. Channels are started and stopped through set-only enable and disable words. A stop request is held until the period in progress completes, so the channel's status bit drops late.

The bus has no back-pressure. A write lands on the clock edge where the write strobe is high, and read data is valid in the same cycle the read strobe is high.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: After reset every output pin is low, the interrupt line is low, and the status, event and channel registers all read zero.
- R2: Channel n's bank sits at byte address 0x200 + n*0x20. Within it, mode is at +0x00, threshold at +0x04, period at +0x08 and the update register at +0x10. Mode, threshold and period read back what was written. Mode bits are [3:0] prescaler, [9] invert and [10] update-to-period; other mode bits read as zero. Unmapped addresses read zero.
- R3: Writing ones to the enable word (0x04) starts those channels, and writing zeros changes nothing. The status word (0x0C) holds one bit per channel, bit n for channel n, set while the channel runs.
- R4: A running channel's counter steps 0,1,...,period-1 and then wraps to 0. With invert clear, the pin is high while counter >= threshold, so a threshold of 0 gives a pin that is high for the whole period.
- R5: With mode bit 9 set, the pin is inverted. This includes its idle level, which is then high.
- R6: With prescaler value k in mode bits [3:0], the counter advances once every 2^k clocks. Values above 10 act as 10.
- R7: With mode bit 10 clear, a write to the update register replaces the threshold at the end of the current period. The period in progress keeps the old threshold.
- R8: With mode bit 10 set, a write to the update register replaces the period at the end of the current period.
- R9: Writing a one to the disable word (0x08) stops that channel only at the end of its current period. Its status bit stays set until then. Afterwards the pin returns to its idle level and a later enable starts again from counter 0.
- R10: Each period end sets bit n of the event word (0x1C). Reading that word clears every bit not being set in the same cycle. The interrupt pin is high while any event bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, same cycle |
| pwm_out | output | 4 | Channel output pins |
| irq | output | 1 | Any period-end event pending |

## Verification
The bench builds the block with its defaults: four channels, 16-bit counters and a prescaler capped at 10 steps. The 4-bit prescaler field can therefore hold 15, which puts the clamp to 10 within reach, and one period at that setting still fits the run time. A scoreboard predicts every pin sample over whole periods, including the period in which a buffered threshold or period update lands. Separate measurements time the deferred stop and the spacing between rising edges under two prescaler settings.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DISABLE = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EVENT   = 12'h01C;

  localparam logic [4:0] BANK_MODE   = 5'h00;
  localparam logic [4:0] BANK_THRESH = 5'h04;
  localparam logic [4:0] BANK_PERIOD = 5'h08;
  localparam logic [4:0] BANK_UPD    = 5'h10;

  localparam int BANK_IDX_W  = 4;
  localparam int MODE_INV_BIT = 9;
  localparam int MODE_UPD_BIT = 10;

  typedef struct packed {
    logic             upd_period;
    logic             invert;
    logic [PRE_W-1:0] pre;
  } mode_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_MAX:0] tick_vec
);
  logic [PRE_MAX-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k <= PRE_MAX; k++) begin : g_tick
    if (k == 0) begin : g_every
      assign tick_vec[k] = 1'b1;
    end else begin : g_div
      assign tick_vec[k] = &div_q[k-1:0];
    end
  end
endmodule

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  input  logic                  re,
  output logic                  en_wr,
  output logic                  dis_wr,
  output logic                  event_clr,
  output logic                  bank_hit,
  output logic [BANK_IDX_W-1:0] bank_idx,
  output logic [4:0]            bank_off,
  output logic [NUM_CH-1:0]     mode_wr,
  output logic [NUM_CH-1:0]     thresh_wr,
  output logic [NUM_CH-1:0]     period_wr,
  output logic [NUM_CH-1:0]     upd_wr
);
  localparam int BANK_TOP_W = ADDR_W - 9;

  assign en_wr     = we && (addr == OFS_ENABLE);
  assign dis_wr    = we && (addr == OFS_DISABLE);
  assign event_clr = re && (addr == OFS_EVENT);

  assign bank_idx = addr[8:5];
  assign bank_off = addr[4:0];
  assign bank_hit = (addr[ADDR_W-1:9] == BANK_TOP_W'(1)) &&
                    (int'(bank_idx) < NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
    logic sel;
    assign sel          = we && bank_hit && (bank_idx == BANK_IDX_W'(i));
    assign mode_wr[i]   = sel && (bank_off == BANK_MODE);
    assign thresh_wr[i] = sel && (bank_off == BANK_THRESH);
    assign period_wr[i] = sel && (bank_off == BANK_PERIOD);
    assign upd_wr[i]    = sel && (bank_off == BANK_UPD);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_MAX:0] tick_vec,
  input  logic             wr_mode,
  input  logic             wr_thresh,
  input  logic             wr_period,
  input  logic             wr_upd,
  input  mode_t            mode_in,
  input  logic [CNT_W-1:0] val_in,
  input  logic             en_set,
  input  logic             dis_set,
  input  logic             flag_clr,
  output mode_t            mode_q,
  output logic [CNT_W-1:0] thresh_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             flag_q,
  output logic             wrap_o,
  output logic             pwm_o
);
  localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(PRE_MAX);

  logic [CNT_W-1:0] upd_val_q;
  logic             upd_tgt_q;
  logic             upd_pend_q;
  logic             dis_pend_q;
  logic [PRE_W-1:0] pre_eff;
  logic             tick_sel;
  logic             at_last;

  assign pre_eff  = (mode_q.pre > PRE_CAP) ? PRE_CAP : mode_q.pre;
  assign tick_sel = tick_vec[pre_eff];
  assign at_last  = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, period_q};
  assign wrap_o   = en_q && tick_sel && at_last;
  assign pwm_o    = mode_q.invert ^ (en_q && (cnt_q >= thresh_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      thresh_q   <= '0;
      period_q   <= '0;
      cnt_q      <= '0;
      en_q       <= 1'b0;
      flag_q     <= 1'b0;
      upd_val_q  <= '0;
      upd_tgt_q  <= 1'b0;
      upd_pend_q <= 1'b0;
      dis_pend_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_in;

      // buffered update lands on the period boundary
      if (wrap_o && upd_pend_q) begin
        if (upd_tgt_q) period_q <= upd_val_q;
        else           thresh_q <= upd_val_q;
        upd_pend_q <= 1'b0;
      end
      if (wr_thresh) thresh_q <= val_in;
      if (wr_period) period_q <= val_in;
      if (wr_upd) begin
        upd_val_q  <= val_in;
        upd_tgt_q  <= mode_q.upd_period;
        upd_pend_q <= 1'b1;
      end

      if (en_q && tick_sel) cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);

      // stop request waits for the period end
      if (dis_set && en_q) dis_pend_q <= 1'b1;
      if (wrap_o && dis_pend_q) begin
        en_q       <= 1'b0;
        cnt_q      <= '0;
        dis_pend_q <= 1'b0;
      end
      if (en_set) begin
        en_q       <= 1'b1;
        dis_pend_q <= 1'b0;
        if (!en_q) cnt_q <= '0;
      end

      if (flag_clr) flag_q <= 1'b0;
      if (wrap_o)   flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int PRE_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              irq
);
  logic [PRE_MAX:0]              tick_vec;
  logic                          en_wr, dis_wr, event_clr, bank_hit;
  logic [BANK_IDX_W-1:0]         bank_idx;
  logic [4:0]                    bank_off;
  logic [NUM_CH-1:0]             mode_wr, thresh_wr, period_wr, upd_wr;
  logic [NUM_CH-1:0]             ch_en, ch_flag, ch_wrap, ch_inv;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt, ch_thresh, ch_period;
  mode_t [NUM_CH-1:0]            ch_mode;
  mode_t                         mode_in;

  assign mode_in.pre        = bus_wdata[PRE_W-1:0];
  assign mode_in.invert     = bus_wdata[MODE_INV_BIT];
  assign mode_in.upd_period = bus_wdata[MODE_UPD_BIT];

  pwm_tick_gen #(.PRE_MAX(PRE_MAX)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec)
  );

  pwm_bus_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr(bus_addr), .we(bus_we), .re(bus_re),
    .en_wr(en_wr), .dis_wr(dis_wr), .event_clr(event_clr),
    .bank_hit(bank_hit), .bank_idx(bank_idx), .bank_off(bank_off),
    .mode_wr(mode_wr), .thresh_wr(thresh_wr),
    .period_wr(period_wr), .upd_wr(upd_wr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W), .PRE_MAX(PRE_MAX)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec),
      .wr_mode(mode_wr[i]), .wr_thresh(thresh_wr[i]),
      .wr_period(period_wr[i]), .wr_upd(upd_wr[i]),
      .mode_in(mode_in), .val_in(bus_wdata[CNT_W-1:0]),
      .en_set(en_wr && bus_wdata[i]),
      .dis_set(dis_wr && bus_wdata[i]),
      .flag_clr(event_clr),
      .mode_q(ch_mode[i]), .thresh_q(ch_thresh[i]), .period_q(ch_period[i]),
      .cnt_q(ch_cnt[i]), .en_q(ch_en[i]), .flag_q(ch_flag[i]),
      .wrap_o(ch_wrap[i]), .pwm_o(pwm_out[i])
    );
    assign ch_inv[i] = ch_mode[i].invert;
  end

  assign irq = |ch_flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == OFS_STATUS) begin
        bus_rdata[NUM_CH-1:0] = ch_en;
      end else if (bus_addr == OFS_EVENT) begin
        bus_rdata[NUM_CH-1:0] = ch_flag;
      end else if (bank_hit) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (bank_idx == BANK_IDX_W'(i)) begin
            case (bank_off)
              BANK_MODE: begin
                bus_rdata[PRE_W-1:0]    = ch_mode[i].pre;
                bus_rdata[MODE_INV_BIT] = ch_mode[i].invert;
                bus_rdata[MODE_UPD_BIT] = ch_mode[i].upd_period;
              end
              BANK_THRESH: bus_rdata[CNT_W-1:0] = ch_thresh[i];
              BANK_PERIOD: bus_rdata[CNT_W-1:0] = ch_period[i];
              default:     bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_quad_ctrl_chk.sv
module pwm_quad_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            ch_wrap,
  input logic [NUM_CH-1:0]            ch_flag,
  input logic [NUM_CH-1:0]            ch_inv,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic                         event_clr
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R5: a stopped channel rests at its idle level
    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> pwm_out[i] == ch_inv[i]);
    // R10: a period end leaves the event bit set
    p_event_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wrap[i] |=> ch_flag[i]);
    // R10: a read with no coincident period end empties the bit
    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (event_clr && !ch_wrap[i]) |=> !ch_flag[i]);
    // R9: a start always begins at counter zero
    p_fresh_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_en[i]) |-> ch_cnt[i] == '0);
    // R9: a channel only stops on a period boundary
    p_late_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_en[i]) |-> $past(ch_wrap[i]));
  end
endmodule

bind pwm_quad_ctrl pwm_quad_ctrl_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_wrap(ch_wrap),
  .ch_flag(ch_flag), .ch_inv(ch_inv), .ch_cnt(ch_cnt),
  .pwm_out(pwm_out), .event_clr(event_clr)
);

// File: tb/pwm_quad_ctrl_test.sv
module pwm_quad_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_EN  = 12'h004;
  localparam logic [11:0] A_DIS = 12'h008;
  localparam logic [11:0] A_ST  = 12'h00C;
  localparam logic [11:0] A_EV  = 12'h01C;

  typedef struct {
    int    ch;
    logic  val;
    string req;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;
  int n_checks = 0, n_err = 0;
  exp_t sb_q[$];

  pwm_quad_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] bank(input int ch, input int off);
    return 12'h200 + 12'(ch * 32) + 12'(off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_re = 0;
  endtask

  task automatic push_wave(input int ch, input int n, input int p0, input int d0,
                           input int sw, input int p1, input int d1,
                           input logic inv, input string req);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.ch  = ch;
      e.req = req;
      if (k < sw) e.val = inv ^ ((k % p0) >= d0);
      else        e.val = inv ^ (((k - sw) % p1) >= d1);
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stop_wait(input logic [3:0] m);
    logic [31:0] s;
    wr(A_DIS, {28'h0, m});
    for (int i = 0; i < 6000; i++) begin
      rd(A_ST, s);
      if ((s[3:0] & m) == 4'h0) break;
    end
  endtask

  task automatic rise_gap(input int ch, output int gap);
    logic prev;
    gap = 0;
    @(negedge clk); prev = pwm_out[ch];
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
    prev = pwm_out[ch];
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      gap++;
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
  endtask

  // monitor: one predicted pin sample per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, 32'(pwm_out[e.ch]), 32'(e.val));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n_hi, gap;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 pins", 32'(pwm_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(A_ST, v);  check("R1 status", v, 0);
    rd(A_EV, v);  check("R1 events", v, 0);
    rd(bank(0, 8), v); check("R1 period", v, 0);

    // R2
    wr(bank(1, 0), 32'hFFFF_F603);
    rd(bank(1, 0), v); check("R2 mode readback", v, 32'h0000_0603);
    wr(bank(1, 4), 32'h1234);
    rd(bank(1, 4), v); check("R2 thresh readback", v, 32'h1234);
    wr(bank(3, 8), 32'hABCD);
    rd(bank(3, 8), v); check("R2 period readback", v, 32'hABCD);
    rd(12'h100, v); check("R2 unmapped", v, 0);
    rd(12'h400, v); check("R2 unmapped bank", v, 0);
    wr(bank(1, 0), 0);

    // R3 zero write has no effect
    wr(A_EN, 0);
    rd(A_ST, v); check("R3 zero enable", v, 0);

    // R4 basic waveform
    wr(bank(0, 8), 10); wr(bank(0, 4), 4);
    wr(A_EN, 1);
    push_wave(0, 25, 10, 4, 1000, 1, 0, 1'b0, "R4 wave");
    drain();
    rd(A_ST, v); check("R3 status running", v, 1);
    wr(A_DIS, 0);
    rd(A_ST, v); check("R3 zero disable", v, 1);
    stop_wait(4'h1);

    // R9 deferred stop
    wr(bank(2, 8), 6); wr(bank(2, 4), 0);
    wr(A_EN, 4);
    n_hi = 0;
    fork
      begin
        for (int i = 0; i < 50; i++) begin
          @(negedge clk);
          if (pwm_out[2]) n_hi++; else break;
        end
      end
      begin
        @(negedge clk);
        wr(A_DIS, 4);
        rd(A_ST, v); check("R9 status held", v, 4);
      end
    join
    check("R9 cycles to stop", n_hi, 6);
    rd(A_ST, v); check("R9 status dropped", v, 0);
    check("R9 idle pin", 32'(pwm_out[2]), 0);
    wr(bank(2, 4), 3);
    wr(A_EN, 4);
    push_wave(2, 12, 6, 3, 1000, 1, 0, 1'b0, "R9 fresh start");
    drain();
    stop_wait(4'h4);

    // R5 inverted
    wr(bank(3, 0), 32'h200); wr(bank(3, 8), 5); wr(bank(3, 4), 2);
    @(negedge clk);
    check("R5 idle high", 32'(pwm_out[3]), 1);
    wr(A_EN, 8);
    push_wave(3, 12, 5, 2, 1000, 1, 0, 1'b1, "R5 wave");
    drain();
    stop_wait(4'h8);
    @(negedge clk);
    check("R5 idle after stop", 32'(pwm_out[3]), 1);

    // R7 buffered threshold update
    rd(A_EV, v);
    wr(bank(0, 8), 8); wr(bank(0, 4), 6);
    wr(A_EN, 1);
    push_wave(0, 20, 8, 6, 8, 8, 2, 1'b0, "R7 wave");
    repeat (2) @(negedge clk);
    wr(bank(0, 16), 2);
    drain();
    check("R10 irq high", 32'(irq), 1);
    stop_wait(4'h1);
    rd(A_EV, v); check("R10 event bit", v, 1);
    rd(A_EV, v); check("R10 cleared on read", v, 0);
    check("R10 irq low", 32'(irq), 0);

    // R8 buffered period update
    wr(bank(1, 0), 32'h400); wr(bank(1, 8), 8); wr(bank(1, 4), 2);
    wr(A_EN, 2);
    push_wave(1, 20, 8, 2, 8, 5, 2, 1'b0, "R8 wave");
    repeat (2) @(negedge clk);
    wr(bank(1, 16), 5);
    drain();
    stop_wait(4'h2);

    // R6 prescaler
    wr(bank(1, 0), 32'h2); wr(bank(1, 8), 4); wr(bank(1, 4), 2);
    wr(A_EN, 2);
    rise_gap(1, gap);
    rise_gap(1, gap); check("R6 prescale 2", gap, 16);
    wr(bank(1, 0), 32'hF);
    rise_gap(1, gap);
    rise_gap(1, gap); check("R6 prescale clamp", gap, 4096);
    stop_wait(4'h2);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule